// File: doc/BRIEF.md
# Transport Stream System Time Counter

This block keeps the system time used to stamp a transport stream capture port. A free-running time base is built from a modulo-300 extension counter and a 33-bit base counter, both advanced by an already-synchronized clock-enable pulse, `stclk_pulse`. A mode bit sets how the base advances. In divided mode the base steps once per extension wrap, so a 27 MHz pulse train yields a 90 kHz base. In direct mode the base steps on every pulse.

A second, programmable counter divides the same pulses into periodic ticks. A comparator watches the base for a programmed value. Each event sets a sticky status flag, provided its enable bit is set. Software clears a flag by writing 1 to it.

Software reaches the block through a small register port. Writes are synchronous. Reads are combinational. Software can also load the counters directly.

Top module: `ts_systime`

## Requirements
- R1: After reset, every register reads 0 and both `tick_flag` and `cmp_flag` are low.
- R2: While the run bit is 0, pulses are ignored. The base, the extension and the tick divider all hold their values.
- R3: With run=1, each pulse advances the extension (address 3) from 0 up to 299 and then wraps it to 0. In divided mode (mode bit 0), the base (addresses 1 and 2) steps by 1 only on that wrap.
- R4: In direct mode (mode bit 1), the base steps by 1 on every accepted pulse. The extension keeps counting modulo 300.
- R5: The 33-bit base wraps from all ones to 0. The low 32 bits are at address 1. Bit 32 is bit 0 of address 2.
- R6: The tick limit is at address 4. With a non-zero limit N, the tick event occurs on every Nth accepted pulse. A limit of 0 produces no tick events.
- R7: If the tick enable is 0, the tick flag is never set.
- R8: The compare value is at address 5 (low 32 bits) and address 6 (bit 32). If the compare enable is 1, the compare flag rises one clock after a counting step makes the base equal to the compare value. If the compare enable is 0, the compare flag never rises.
- R9: The status register is at address 7, with the tick flag in bit 0 and the compare flag in bit 1. Both flags stay set until 1 is written to their bit. A new event in the same cycle as the clear leaves the flag set.
- R10: The control register is at address 0, with run in bit 0, mode in bit 1, tick enable in bit 2 and compare enable in bit 3. Bits 31:4 read 0 whatever is written to them.
- R11: A write to the base or the extension is visible on the next clock and replaces any increment in that cycle. An extension write above 299 loads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stclk_pulse | input | 1 | Synchronized one-cycle time-base enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data, combinational |
| tick_flag | output | 1 | Sticky tick status |
| cmp_flag | output | 1 | Sticky compare status |

## Verification
The assertions assume that `stclk_pulse` is already in the block clock domain and lasts at most one clock per pulse. They also assume that at most one register is written per cycle, and they read any cycle with `wr_en` high as a possible counter load.

The stimulus drives all inputs on the falling edge, so each pulse is a clean single-cycle enable. Random writes keep base and compare values small, so that matches actually occur. Extension writes sometimes exceed 299 to exercise the load clamp.

// File: rtl/ts_systime_pkg.sv
package ts_systime_pkg;

   typedef enum logic [2:0] {
      A_CTRL     = 3'd0,
      A_BASE_LO  = 3'd1,
      A_BASE_HI  = 3'd2,
      A_EXT      = 3'd3,
      A_TICK_LIM = 3'd4,
      A_CMP_LO   = 3'd5,
      A_CMP_HI   = 3'd6,
      A_STATUS   = 3'd7
   } reg_addr_e;

   typedef struct packed {
      logic cmp_en;
      logic tick_en;
      logic mode;
      logic run;
   } ctrl_t;

   localparam int CTRL_W = 4;

endpackage

// File: rtl/ts_time_core.sv
module ts_time_core #(
   parameter int BASE_W  = 33,
   parameter int DATA_W  = 32,
   parameter int EXT_MOD = 300,
   localparam int EXT_W  = $clog2(EXT_MOD),
   localparam int HI_W   = BASE_W - DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              mode,
   input  logic              ld_lo,
   input  logic              ld_hi,
   input  logic              ld_ext,
   input  logic [DATA_W-1:0] ld_data,
   output logic [BASE_W-1:0] base_q,
   output logic [EXT_W-1:0]  ext_q,
   output logic              step_q
);

   logic              ext_wrap;
   logic              base_inc;
   logic              base_ld;
   logic [BASE_W-1:0] base_d;

   assign ext_wrap = ext_q >= EXT_W'(EXT_MOD - 1);
   assign base_inc = adv && (mode || ext_wrap);
   assign base_ld  = ld_lo || ld_hi;

   always_comb begin
      base_d = base_q;
      if (ld_lo)
         base_d[DATA_W-1:0] = ld_data;
      if (ld_hi)
         base_d[BASE_W-1:DATA_W] = ld_data[HI_W-1:0];
      if (!base_ld && base_inc)
         base_d = base_q + BASE_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_q  <= '0;
         base_q <= '0;
         step_q <= 1'b0;
      end else begin
         if (ld_ext)
            ext_q <= (ld_data < DATA_W'(EXT_MOD)) ? ld_data[EXT_W-1:0] : '0;
         else if (adv)
            ext_q <= ext_wrap ? '0 : ext_q + EXT_W'(1);
         base_q <= base_d;
         step_q <= base_inc && !base_ld;
      end
   end

endmodule

// File: rtl/ts_tick_gen.sv
module ts_tick_gen #(
   parameter int TICK_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic [TICK_W-1:0] limit,
   output logic              hit
);

   logic [TICK_W-1:0] cnt_q;
   logic [TICK_W:0]   cnt_nxt;
   logic              lim_zero;

   assign cnt_nxt  = {1'b0, cnt_q} + (TICK_W+1)'(1);
   assign lim_zero = (limit == '0);
   assign hit      = adv && !lim_zero && (cnt_nxt >= {1'b0, limit});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (adv) begin
         if (lim_zero || hit)
            cnt_q <= '0;
         else
            cnt_q <= cnt_nxt[TICK_W-1:0];
      end
   end

endmodule

// File: rtl/ts_sticky_flag.sv
module ts_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= 1'b0;
      else
         q <= (q && !clr) || set;
   end

endmodule

// File: rtl/ts_systime.sv
module ts_systime
   import ts_systime_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int BASE_W  = 33,
   parameter int EXT_MOD = 300,
   parameter int TICK_W  = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stclk_pulse,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [2:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              tick_flag,
   output logic              cmp_flag
);

   localparam int EXT_W = $clog2(EXT_MOD);
   localparam int HI_W  = BASE_W - DATA_W;

   generate
      if (BASE_W <= DATA_W || HI_W > DATA_W) begin : g_bad_base
         $error("ts_systime: BASE_W must lie in (DATA_W, 2*DATA_W]");
      end
      if (TICK_W > DATA_W || TICK_W < 1) begin : g_bad_tick
         $error("ts_systime: TICK_W must lie in [1, DATA_W]");
      end
      if (EXT_MOD < 2 || EXT_W > DATA_W) begin : g_bad_ext
         $error("ts_systime: EXT_MOD out of range");
      end
   endgenerate

   ctrl_t             ctrl_q;
   logic [TICK_W-1:0] lim_q;
   logic [BASE_W-1:0] cmp_q;
   logic [BASE_W-1:0] base_q;
   logic [EXT_W-1:0]  ext_q;
   logic              step_q;
   logic              tick_hit;
   logic              adv;
   reg_addr_e         wa;

   assign wa  = reg_addr_e'(wr_addr);
   assign adv = stclk_pulse && ctrl_q.run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         lim_q  <= '0;
         cmp_q  <= '0;
      end else if (wr_en) begin
         case (wa)
            A_CTRL:     ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
            A_TICK_LIM: lim_q  <= wr_data[TICK_W-1:0];
            A_CMP_LO:   cmp_q[DATA_W-1:0] <= wr_data;
            A_CMP_HI:   cmp_q[BASE_W-1:DATA_W] <= wr_data[HI_W-1:0];
            default: ;
         endcase
      end
   end

   ts_time_core #(
      .BASE_W (BASE_W),
      .DATA_W (DATA_W),
      .EXT_MOD(EXT_MOD)
   ) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (adv),
      .mode   (ctrl_q.mode),
      .ld_lo  (wr_en && wa == A_BASE_LO),
      .ld_hi  (wr_en && wa == A_BASE_HI),
      .ld_ext (wr_en && wa == A_EXT),
      .ld_data(wr_data),
      .base_q (base_q),
      .ext_q  (ext_q),
      .step_q (step_q)
   );

   ts_tick_gen #(.TICK_W(TICK_W)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .adv  (adv),
      .limit(lim_q),
      .hit  (tick_hit)
   );

   ts_sticky_flag u_tick_flag (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (tick_hit && ctrl_q.tick_en),
      .clr  (wr_en && wa == A_STATUS && wr_data[0]),
      .q    (tick_flag)
   );

   ts_sticky_flag u_cmp_flag (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (step_q && (base_q == cmp_q) && ctrl_q.cmp_en),
      .clr  (wr_en && wa == A_STATUS && wr_data[1]),
      .q    (cmp_flag)
   );

   always_comb begin
      case (reg_addr_e'(rd_addr))
         A_CTRL:     rd_data = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
         A_BASE_LO:  rd_data = base_q[DATA_W-1:0];
         A_BASE_HI:  rd_data = {{(2*DATA_W-BASE_W){1'b0}}, base_q[BASE_W-1:DATA_W]};
         A_EXT:      rd_data = {{(DATA_W-EXT_W){1'b0}}, ext_q};
         A_TICK_LIM: rd_data = {{(DATA_W-TICK_W){1'b0}}, lim_q};
         A_CMP_LO:   rd_data = cmp_q[DATA_W-1:0];
         A_CMP_HI:   rd_data = {{(2*DATA_W-BASE_W){1'b0}}, cmp_q[BASE_W-1:DATA_W]};
         A_STATUS:   rd_data = {{(DATA_W-2){1'b0}}, cmp_flag, tick_flag};
         default:    rd_data = '0;
      endcase
   end

endmodule

// File: rtl/ts_systime_chk.sv
module ts_systime_chk #(
   parameter int DATA_W  = 32,
   parameter int BASE_W  = 33,
   parameter int EXT_MOD = 300,
   localparam int EXT_W  = $clog2(EXT_MOD)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              stclk_pulse,
   input logic              wr_en,
   input logic [2:0]        wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [3:0]        ctrl_bits,
   input logic [BASE_W-1:0] base_q,
   input logic [EXT_W-1:0]  ext_q,
   input logic              tick_flag,
   input logic              cmp_flag
);

   p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_bits[0] && !wr_en) |=> ($stable(base_q) && $stable(ext_q)));

   p_ext_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ext_q < EXT_W'(EXT_MOD));

   p_direct_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_bits[0] && ctrl_bits[1] && stclk_pulse && !wr_en)
      |=> ((base_q - $past(base_q)) == BASE_W'(1)));

   p_tick_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_bits[2] && !tick_flag) |=> !tick_flag);

   p_cmp_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_bits[3] && !cmp_flag) |=> !cmp_flag);

   p_tick_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_flag && !(wr_en && wr_addr == 3'd7 && wr_data[0])) |=> tick_flag);

   p_cmp_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_flag && !(wr_en && wr_addr == 3'd7 && wr_data[1])) |=> cmp_flag);

endmodule

bind ts_systime ts_systime_chk #(
   .DATA_W (DATA_W),
   .BASE_W (BASE_W),
   .EXT_MOD(EXT_MOD)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .stclk_pulse(stclk_pulse),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .ctrl_bits  (ctrl_q),
   .base_q     (base_q),
   .ext_q      (ext_q),
   .tick_flag  (tick_flag),
   .cmp_flag   (cmp_flag)
);

// File: tb/ts_systime_bench.sv
`timescale 1ns/1ps
module ts_systime_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        stclk_pulse = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = 3'd0;
   logic [31:0] wr_data = 32'd0;
   logic [2:0]  rd_addr = 3'd0;
   logic [31:0] rd_data;
   logic        tick_flag;
   logic        cmp_flag;

   always #2.5 clk = ~clk;

   ts_systime u_ts_systime (
      .clk(clk), .rst_n(rst_n), .stclk_pulse(stclk_pulse),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .tick_flag(tick_flag), .cmp_flag(cmp_flag)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // reference model state
   logic [32:0] m_base = 33'd0, m_cmp = 33'd0;
   logic [8:0]  m_ext = 9'd0;
   logic [23:0] m_tcnt = 24'd0, m_lim = 24'd0;
   logic [3:0]  m_ctrl = 4'd0;
   bit          m_tick = 1'b0, m_cmpf = 1'b0, m_upd = 1'b0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic model(input bit p, input bit we, input logic [2:0] a, input logic [31:0] d);
      bit adv, wrap, inc, tick_ev, cmp_ev, ldb;
      logic [1:0] clr;
      adv     = p && m_ctrl[0];
      wrap    = (m_ext == 9'd299);
      inc     = adv && (m_ctrl[1] || wrap);
      tick_ev = adv && (m_lim != 24'd0) && ({1'b0, m_tcnt} + 25'd1 >= {1'b0, m_lim});
      cmp_ev  = m_upd && (m_base == m_cmp);
      clr     = (we && a == 3'd7) ? d[1:0] : 2'b00;
      m_tick  = (m_tick && !clr[0]) || (tick_ev && m_ctrl[2]);
      m_cmpf  = (m_cmpf && !clr[1]) || (cmp_ev && m_ctrl[3]);
      if (adv) m_tcnt = (m_lim == 24'd0 || tick_ev) ? 24'd0 : m_tcnt + 24'd1;
      ldb   = we && (a == 3'd1 || a == 3'd2);
      m_upd = inc && !ldb;
      if (we && a == 3'd3) m_ext = (d < 32'd300) ? d[8:0] : 9'd0;
      else if (adv)        m_ext = wrap ? 9'd0 : m_ext + 9'd1;
      if (we && a == 3'd1)      m_base[31:0] = d;
      else if (we && a == 3'd2) m_base[32] = d[0];
      else if (inc)             m_base = m_base + 33'd1;
      if (we && a == 3'd0) m_ctrl = d[3:0];
      if (we && a == 3'd4) m_lim = d[23:0];
      if (we && a == 3'd5) m_cmp[31:0] = d;
      if (we && a == 3'd6) m_cmp[32] = d[0];
   endtask

   // called at a falling edge; leaves at the next falling edge
   task automatic step(input bit p, input bit we, input logic [2:0] a, input logic [31:0] d);
      stclk_pulse = p; wr_en = we; wr_addr = a; wr_data = d;
      @(posedge clk);
      model(p, we, a, d);
      @(negedge clk);
      stclk_pulse = 1'b0; wr_en = 1'b0;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      step(1'b0, 1'b1, a, d);
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) step(1'b1, 1'b0, 3'd0, 32'd0);
   endtask

   task automatic chk_reg(input string req, input logic [2:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd_addr = a;
      #0.5;
      v = rd_data;
      check(req, v, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 8; a++) chk_reg("R1 reg", 3'(a), 32'd0);
      check("R1 tick_flag", {31'd0, tick_flag}, 32'd0);
      check("R1 cmp_flag", {31'd0, cmp_flag}, 32'd0);

      // R10 reserved control bits
      wr(3'd0, 32'hFFFF_FFFF);
      chk_reg("R10 ctrl", 3'd0, 32'h0000_000F);
      wr(3'd0, 32'd0);

      // R2 stopped timer ignores pulses
      wr(3'd4, 32'd2);
      wr(3'd0, 32'h4);
      pulses(10);
      chk_reg("R2 base", 3'd1, 32'd0);
      chk_reg("R2 ext", 3'd3, 32'd0);
      check("R2 no tick", {31'd0, tick_flag}, 32'd0);

      // R3 divided mode
      wr(3'd0, 32'h1);
      pulses(299);
      chk_reg("R3 ext299", 3'd3, 32'd299);
      chk_reg("R3 base0", 3'd1, 32'd0);
      pulses(1);
      chk_reg("R3 ext wrap", 3'd3, 32'd0);
      chk_reg("R3 base1", 3'd1, 32'd1);

      // R4 direct mode
      wr(3'd0, 32'h3);
      pulses(5);
      chk_reg("R4 base", 3'd1, 32'd6);
      chk_reg("R4 ext", 3'd3, 32'd5);

      // R5 base wrap
      wr(3'd1, 32'hFFFF_FFFF);
      wr(3'd2, 32'd1);
      chk_reg("R5 hi", 3'd2, 32'd1);
      pulses(1);
      chk_reg("R5 lo", 3'd1, 32'd0);
      chk_reg("R5 hi0", 3'd2, 32'd0);

      // R11 load overrides increment, ext clamp
      step(1'b1, 1'b1, 3'd1, 32'd100);
      chk_reg("R11 base load", 3'd1, 32'd100);
      wr(3'd3, 32'd350);
      chk_reg("R11 ext clamp", 3'd3, 32'd0);
      step(1'b1, 1'b1, 3'd3, 32'd40);
      chk_reg("R11 ext load", 3'd3, 32'd40);

      // R6 tick period
      wr(3'd0, 32'h5);
      wr(3'd7, 32'h3);
      wr(3'd4, 32'd4);
      wr(3'd3, 32'd0);
      pulses(3);
      check("R6 before", {31'd0, tick_flag}, 32'd0);
      pulses(1);
      check("R6 on limit", {31'd0, tick_flag}, 32'd1);
      // R9 clear
      wr(3'd7, 32'h1);
      check("R9 cleared", {31'd0, tick_flag}, 32'd0);
      // R6 zero limit
      wr(3'd4, 32'd0);
      pulses(20);
      check("R6 zero limit", {31'd0, tick_flag}, 32'd0);

      // R7 tick disabled
      wr(3'd0, 32'h1);
      wr(3'd4, 32'd2);
      pulses(10);
      check("R7 disabled", {31'd0, tick_flag}, 32'd0);

      // R9 simultaneous set and clear
      wr(3'd0, 32'h5);
      wr(3'd4, 32'd1);
      pulses(1);
      check("R9 set", {31'd0, tick_flag}, 32'd1);
      step(1'b1, 1'b1, 3'd7, 32'h1);
      check("R9 set wins", {31'd0, tick_flag}, 32'd1);
      wr(3'd7, 32'h1);

      // R8 compare
      wr(3'd0, 32'hB);
      wr(3'd1, 32'd10);
      wr(3'd2, 32'd0);
      wr(3'd5, 32'd12);
      wr(3'd6, 32'd0);
      pulses(1);
      check("R8 not equal", {31'd0, cmp_flag}, 32'd0);
      pulses(1);
      check("R8 equal same cycle", {31'd0, cmp_flag}, 32'd0);
      step(1'b0, 1'b0, 3'd0, 32'd0);
      check("R8 flag rises", {31'd0, cmp_flag}, 32'd1);
      chk_reg("R9 status", 3'd7, 32'h2);
      wr(3'd7, 32'h2);
      wr(3'd0, 32'h3);
      wr(3'd1, 32'd10);
      pulses(4);
      check("R8 disabled", {31'd0, cmp_flag}, 32'd0);

      // randomized phase against the model (R2-R11)
      for (int i = 0; i < 4000; i++) begin
         bit p, we;
         logic [2:0] a;
         logic [31:0] d;
         p  = ($urandom % 2) == 0;
         we = ($urandom % 12) == 0;
         a  = 3'($urandom % 8);
         case (a)
            3'd0: d = $urandom % 16;
            3'd1, 3'd5: d = $urandom % 400;
            3'd3: d = $urandom % 320;
            3'd4: d = $urandom % 6;
            3'd7: d = $urandom % 4;
            default: d = 32'd0;
         endcase
         step(p, we, a, d);
         check("R6 random tick", {31'd0, tick_flag}, {31'd0, m_tick});
         check("R8 random cmp", {31'd0, cmp_flag}, {31'd0, m_cmpf});
         if (i % 25 == 0) begin
            chk_reg("R3 random base", 3'd1, m_base[31:0]);
            chk_reg("R11 random ext", 3'd3, {23'd0, m_ext});
         end
      end

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule